// File: doc/BRIEF.md
# Read Return Scheduler with Programmable CAS Latency

This block decides, clock by clock, when a double-data-rate memory model drives its read data and its data strobe. A one-cycle read strobe is sampled together with the programmed CAS latency and a burst-length code. The block then lays out three windows. The first is a strobe preamble of one full clock. The second is the data window, with one beat on the rising half and one on the falling half of each clock. The third is a strobe postamble of one half clock after the last beat. During the data window it also gives the index of the beat being driven on each half.

Each command carries its own latency and burst length through a short delay line, one stage per clock. Changing the programmed values therefore only affects commands that come after the change. When a read follows the previous one by exactly half its burst length in clocks, the two bursts join into one unbroken stream, with no preamble and no postamble between them. The output access delay is taken as zero, so every window boundary falls on a clock edge. The storage array, the write path and clock generation live elsewhere. The control pins are plain, level-sampled signals with no handshake. A read is sampled on every rising edge where `rd_cmd` is high.

Top module: `rd_return_sched`

## Requirements
- R1: With an effective latency of 2, a read sampled at rising edge n makes `dq_valid_rise` and `dq_valid_fall` high in the clock cycle that follows edge n+1.
- R2: With an effective latency of 3, a read sampled at rising edge n makes the data valid starting in the cycle that follows edge n+2. This is one full cycle later than with latency 2.
- R3: In the cycle just before a burst's first data cycle, `dqs_oe_rise`, `dqs_oe_fall` and `dqs_pre` are all high and no valid flag is high. The exception is when that cycle already carries data.
- R4: In the cycle after a burst's last data cycle, if no data follows, only `dqs_oe_rise` (the first half-cycle) is high and `dqs_oe_fall` is low. The exception is when that cycle is a preamble.
- R5: `burst_code` selects the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8 and 3 gives 16. The data window lasts burst/2 clock cycles.
- R6: In data cycle k of a burst (k counted from 0), `beat_rise` is 2k and `beat_fall` is 2k+1. Both are 0 outside the data window.
- R7: A read issued burst/2 clocks after the previous one, with the same latency, keeps both valid flags high across the joint. No preamble or postamble appears between the bursts, and the beat index restarts at 0 in the first cycle of the new burst.
- R8: Latency and burst length are taken when the read is sampled. Changing `cas_lat` or `burst_code` while that read is in flight does not move or resize its windows.
- R9: A `cas_lat` value below 2 acts as 2 and a value above 3 acts as 3.
- R10: While `rst_n` is low every output is 0, and a burst in flight is discarded. After reset, and whenever no read is scheduled, all outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; reads sampled on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | Read strobe, one cycle per read |
| cas_lat | input | 2 | Programmed CAS latency in clocks (2 or 3) |
| burst_code | input | 2 | Burst-length code, 2 << code beats |
| dqs_oe_rise | output | 1 | Strobe enable for the first half of the cycle |
| dqs_oe_fall | output | 1 | Strobe enable for the second half of the cycle |
| dqs_pre | output | 1 | Strobe held low as preamble this cycle |
| dq_valid_rise | output | 1 | Data beat valid on the rising half |
| dq_valid_fall | output | 1 | Data beat valid on the falling half |
| beat_rise | output | 4 | Beat index driven on the rising half |
| beat_fall | output | 4 | Beat index driven on the falling half |

## Verification
The hardest situations to reach from the ports are the exact joints between two bursts. One is the gapless case, where a new preamble falls on the previous burst's last data cycle. The other is the case one clock later, where a preamble falls on the previous burst's postamble. The bench reaches both by computing each second read's issue cycle from the burst code: half the burst length in clocks for the gapless case, and one more for the postamble case. It does this for every latency and burst-code pair. Changes to latency and burst length in flight are brought about by rewriting `cas_lat` and `burst_code` in the cycle right after a latency-3 read. The clamp is reached by issuing reads with `cas_lat` values 0 and 1.

// File: rtl/rds_pkg.sv
package rds_pkg;
  localparam int BC_W = 2;

  typedef struct packed {
    logic            v;
    logic [BC_W-1:0] bc;
  } rd_tok_t;
endpackage

// File: rtl/rds_launch_line.sv
module rds_launch_line
  import rds_pkg::*;
#(
  parameter int MIN_CL = 2,
  parameter int MAX_CL = 3,
  parameter int CAS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_i,
  input  logic [CAS_W-1:0] cas_i,
  input  logic [BC_W-1:0]  bc_i,
  output logic             launch_o,
  output logic [BC_W-1:0]  launch_bc_o
);
  localparam int DEPTH  = MAX_CL - MIN_CL;
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH + 1) : 1;

  logic [SLOT_W-1:0] slot;

  // Clamp the programmed latency into [MIN_CL, MAX_CL] and turn it into a
  // stage offset: 0 means the preamble begins in the cycle just sampled.
  always_comb begin
    int lat;
    lat = int'(cas_i);
    if (lat < MIN_CL) lat = MIN_CL;
    if (lat > MAX_CL) lat = MAX_CL;
    slot = SLOT_W'(lat - MIN_CL);
  end

  if (DEPTH == 0) begin : g_direct
    assign launch_o    = cmd_i;
    assign launch_bc_o = bc_i;
  end else begin : g_delay
    rd_tok_t stg [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_stg
      rd_tok_t q;
      rd_tok_t nxt;
      if (j == DEPTH - 1) begin : g_tail
        assign nxt = '0;
      end else begin : g_mid
        assign nxt = stg[j+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  q <= '0;
        else if (cmd_i && slot == SLOT_W'(j + 1))    q <= '{v: 1'b1, bc: bc_i};
        else                                         q <= nxt;
      end
      assign stg[j] = q;
    end

    // Oldest token has priority over a zero-offset command.
    always_comb begin
      if (stg[0].v) begin
        launch_o    = 1'b1;
        launch_bc_o = stg[0].bc;
      end else begin
        launch_o    = cmd_i && (slot == '0);
        launch_bc_o = bc_i;
      end
    end

    // R2: a command placed one stage out reaches the head one clock later
    a_r2_stage_hop: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i && slot == SLOT_W'(1)) |=> stg[0].v);
  end
endmodule

// File: rtl/rds_burst_eng.sv
module rds_burst_eng
  import rds_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic [BC_W-1:0]  launch_bc_i,
  output logic             pre_o,
  output logic             act_o,
  output logic             post_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             pre_q, act_q, post_q;
  logic [BC_W-1:0]  pre_bc_q;
  logic [CNT_W-1:0] cnt_q, last_q;
  logic [CNT_W:0]   halfn;
  logic [CNT_W-1:0] new_last;
  logic             at_last;

  // Number of data cycles is 1 << code; keep its last index.
  assign halfn    = {{CNT_W{1'b0}}, 1'b1} << pre_bc_q;
  assign new_last = halfn[CNT_W-1:0] - CNT_W'(1);
  assign at_last  = act_q && (cnt_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= 1'b0;
      pre_bc_q <= '0;
      act_q    <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
      post_q   <= 1'b0;
    end else begin
      pre_q    <= launch_i;
      pre_bc_q <= launch_bc_i;
      post_q   <= at_last && !pre_q;
      if (pre_q) begin
        act_q  <= 1'b1;
        cnt_q  <= '0;
        last_q <= new_last;
      end else if (act_q && !at_last) begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end else begin
        act_q  <= 1'b0;
        cnt_q  <= '0;
      end
    end
  end

  assign pre_o  = pre_q;
  assign act_o  = act_q;
  assign post_o = post_q;
  assign cnt_o  = cnt_q;

  // R3: a preamble cycle is always followed by the first data cycle
  a_r3_pre_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q |=> (act_q && cnt_q == '0));

  // R6: inside a burst the cycle counter steps by one
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && !$past(pre_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R5: the counter never passes the captured burst end
  a_r5_within_len: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q <= last_q));

  // R4: a postamble only follows a data cycle and never overlaps data
  a_r4_post_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    post_q |-> (!act_q && $past(act_q)));
endmodule

// File: rtl/rd_return_sched.sv
module rd_return_sched
  import rds_pkg::*;
#(
  parameter int MIN_CL = 2,
  parameter int MAX_CL = 3,
  parameter int CAS_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_cmd,
  input  logic [CAS_W-1:0]    cas_lat,
  input  logic [BC_W-1:0]     burst_code,
  output logic                dqs_oe_rise,
  output logic                dqs_oe_fall,
  output logic                dqs_pre,
  output logic                dq_valid_rise,
  output logic                dq_valid_fall,
  output logic [BC_W+1:0]     beat_rise,
  output logic [BC_W+1:0]     beat_fall
);
  localparam int MAX_CODE = (1 << BC_W) - 1;
  localparam int CNT_W    = (MAX_CODE > 0) ? MAX_CODE : 1;
  localparam int IDX_W    = BC_W + 2;

  logic             launch;
  logic [BC_W-1:0]  launch_bc;
  logic             pre, act, post;
  logic [CNT_W-1:0] cnt;

  rds_launch_line #(
    .MIN_CL (MIN_CL),
    .MAX_CL (MAX_CL),
    .CAS_W  (CAS_W)
  ) u_line (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (rd_cmd),
    .cas_i       (cas_lat),
    .bc_i        (burst_code),
    .launch_o    (launch),
    .launch_bc_o (launch_bc)
  );

  rds_burst_eng #(
    .CNT_W (CNT_W)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (launch),
    .launch_bc_i (launch_bc),
    .pre_o       (pre),
    .act_o       (act),
    .post_o      (post),
    .cnt_o       (cnt)
  );

  logic [IDX_W-1:0] idx_base;
  assign idx_base = IDX_W'({cnt, 1'b0});

  always_comb begin
    dqs_oe_fall   = pre | act;
    dqs_oe_rise   = pre | act | post;
    dqs_pre       = pre & ~act;
    dq_valid_rise = act;
    dq_valid_fall = act;
    beat_rise     = act ? idx_base : '0;
    beat_fall     = act ? (idx_base | IDX_W'(1)) : '0;
  end

  // R1: valid data is always framed by an enabled strobe on both halves
  a_r1_valid_framed: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid_rise |-> (dqs_oe_rise && dqs_oe_fall));

  // R4: a half-cycle-only strobe appears right after falling-half data
  a_r4_half_post: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_oe_rise && !dqs_oe_fall) |-> $past(dq_valid_fall));

  // R10: outputs are quiet while reset is held
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !(dqs_oe_rise || dqs_oe_fall || dq_valid_rise || dq_valid_fall));
endmodule

// File: tb/rd_return_sched_test.sv
module rd_return_sched_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_cmd = 1'b0;
  logic [1:0] cas_lat = 2'd2;
  logic [1:0] burst_code = 2'd0;
  logic       dqs_oe_rise, dqs_oe_fall, dqs_pre, dq_valid_rise, dq_valid_fall;
  logic [3:0] beat_rise, beat_fall;

  rd_return_sched uut (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .cas_lat(cas_lat),
    .burst_code(burst_code), .dqs_oe_rise(dqs_oe_rise), .dqs_oe_fall(dqs_oe_fall),
    .dqs_pre(dqs_pre), .dq_valid_rise(dq_valid_rise), .dq_valid_fall(dq_valid_fall),
    .beat_rise(beat_rise), .beat_fall(beat_fall)
  );

  always #2 clk = ~clk;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    skip = 1'b1;
  string phase = "R10 reset";

  bit e_pre  [256];
  bit e_data [256];
  bit e_post [256];
  int e_idx  [256];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s: got %0d expected %0d (cycle %0d)", req, phase, what, act, exp, cyc);
    end
  endtask

  task automatic clear_ring();
    for (int i = 0; i < 256; i++) begin
      e_pre[i] = 0; e_data[i] = 0; e_post[i] = 0; e_idx[i] = 0;
    end
  endtask

  // Expected windows for a read sampled at edge n (R1, R2, R5, R9)
  task automatic mark(input int n, input int raw_cl, input int code);
    int lat;
    int h;
    lat = (raw_cl < 2) ? 2 : ((raw_cl > 3) ? 3 : raw_cl);
    h   = 1 << code;
    e_pre[(n + lat - 2) % 256] = 1;
    for (int k = 0; k < h; k++) begin
      e_data[(n + lat - 1 + k) % 256] = 1;
      e_idx[(n + lat - 1 + k) % 256]  = 2 * k;
    end
    e_post[(n + lat - 1 + h) % 256] = 1;
  endtask

  // Called right after a falling edge; the read is sampled at the next rising edge.
  task automatic issue(input int raw_cl, input int code);
    rd_cmd     = 1'b1;
    cas_lat    = raw_cl[1:0];
    burst_code = code[1:0];
    mark(cyc + 1, raw_cl, code);
    @(negedge clk);
    rd_cmd = 1'b0;
  endtask

  // Cycle-by-cycle comparison against the arithmetic schedule
  always @(negedge clk) begin
    if (!skip) begin
      int s;
      bit d, p, q;
      s = cyc % 256;
      d = e_data[s];
      p = e_pre[s];
      q = e_post[s];
      chk("R1/R2/R5", "valid_rise", dq_valid_rise, d);
      chk("R1/R2/R5", "valid_fall", dq_valid_fall, d);
      chk("R3", "dqs_pre", dqs_pre, p & ~d);
      chk("R3/R4", "oe_fall", dqs_oe_fall, p | d);
      chk("R3/R4", "oe_rise", dqs_oe_rise, p | d | q);
      chk("R6", "beat_rise", beat_rise, d ? e_idx[s] : 0);
      chk("R6", "beat_fall", beat_fall, d ? e_idx[s] + 1 : 0);
      e_pre[s] = 0; e_data[s] = 0; e_post[s] = 0; e_idx[s] = 0;
    end
  end

  task automatic check_quiet(input string what);
    chk("R10", {what, " oe_rise"}, dqs_oe_rise, 0);
    chk("R10", {what, " oe_fall"}, dqs_oe_fall, 0);
    chk("R10", {what, " valid"}, dq_valid_rise | dq_valid_fall, 0);
    chk("R10", {what, " beat"}, beat_rise | beat_fall, 0);
  endtask

  initial begin
    #(4 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (cycle %0d)", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_ring();
    repeat (3) @(negedge clk);
    check_quiet("R10 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    skip = 1'b0;
    repeat (3) @(negedge clk);

    // Single reads, every latency and burst code
    for (int cl = 2; cl <= 3; cl++) begin
      for (int code = 0; code < 4; code++) begin
        phase = "R1/R2/R5 single";
        issue(cl, code);
        repeat (14) @(negedge clk);
      end
    end

    // R7: gapless pair, second read burst/2 clocks after the first
    for (int cl = 2; cl <= 3; cl++) begin
      for (int code = 0; code < 4; code++) begin
        phase = "R7 gapless";
        issue(cl, code);
        repeat ((1 << code) - 1) @(negedge clk);
        issue(cl, code);
        repeat (22) @(negedge clk);
      end
    end

    // R3/R4: one clock further apart, postamble meets the next preamble
    for (int cl = 2; cl <= 3; cl++) begin
      for (int code = 0; code < 4; code++) begin
        phase = "R4 post-into-pre";
        issue(cl, code);
        repeat (1 << code) @(negedge clk);
        issue(cl, (code + 1) % 4);
        repeat (24) @(negedge clk);
      end
    end

    // R8: settings rewritten while a latency-3 read is in flight
    phase = "R8 in-flight change";
    issue(3, 1);
    cas_lat    = 2'd2;
    burst_code = 2'd3;
    repeat (10) @(negedge clk);

    // R9: low latency codes clamp to 2
    phase = "R9 clamp";
    issue(0, 1);
    repeat (8) @(negedge clk);
    issue(1, 2);
    repeat (10) @(negedge clk);

    // R10: reset in the middle of a burst discards it
    phase = "R10 mid-burst reset";
    issue(3, 3);
    repeat (4) @(negedge clk);
    skip = 1'b1;
    #1 rst_n = 1'b0;
    @(negedge clk);
    check_quiet("R10 during reset");
    clear_ring();
    #1 rst_n = 1'b1;
    @(negedge clk);
    skip = 1'b0;
    repeat (12) @(negedge clk);
    check_quiet("R10 after reset");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule